// File: doc/BRIEF.md
# Serial CRC-16 Engine for Disk Field Framing

This block keeps the 16-bit cyclic redundancy remainder for a floppy disk formatter's serial datapath. It uses the generator x^16 + x^12 + x^5 + 1 (0x1021) and starts every field from an all-ones register. The covered span of a field begins at its address mark bytes and ends just before its two check bytes. Data arrives one bit per enabled cycle, most significant bit first. Framing logic outside the block tells it when a field starts by pulsing the preset input.

On write, the framer absorbs the field and then switches the engine to emit mode. In that mode the register drives the serial output with its top bit and shifts in zeros, so sixteen emit cycles put the two check bytes on the line, high byte first. On read, the framer absorbs the whole field together with its two stored check bytes and then strobes the check input. A nonzero remainder raises the error flag. Emitting is the same shift as absorbing the register's own top bit, so a single feedback path serves both directions.

Top module: `crc16_engine`

## Requirements
- R1: While reset is high, the register is loaded with 0xFFFF and the error flag is cleared. Both values are visible after the first clock edge with reset high.
- R2: A cycle with preset high loads 0xFFFF into the register and clears the error flag at that clock edge.
- R3: Preset takes priority over a bit-enable or a check strobe in the same cycle. The result is 0xFFFF and error 0, whatever the data bit and mode are.
- R4: In absorb mode (mode input 0), an enabled cycle with data bit d computes f = d XOR r[15] and updates the register to (r << 1) XOR (f ? 0x1021 : 0), truncated to 16 bits. A byte is therefore fed most significant bit first.
- R5: In a cycle with neither preset nor bit-enable, the remainder keeps its value.
- R6: In emit mode (mode input 1), the serial output equals r[15] during the cycle. An enabled cycle shifts the register left and fills with 0, so 16 emit cycles leave 0 and put the remainder on the line MSB first.
- R7: A check strobe without preset sets the error flag to 1 if the remainder before that edge is nonzero and to 0 otherwise. Between strobes and presets the flag holds its value.
- R8: Absorbing A1 A1 A1 FE 00 00 01 02 from preset gives the arithmetic CRC of those bytes. Absorbing those bytes followed by that CRC, high byte first, leaves remainder 0, and a check then reports no error.
- R9: Inverting any single bit of that 80-bit field (payload or CRC) leaves a nonzero remainder, and a check then reports an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_i | input | 1 | Start of field: load all ones, clear error |
| bit_en_i | input | 1 | Advance the register by one bit this cycle |
| mode_i | input | 1 | 0 = absorb bit_i, 1 = emit register top bit |
| bit_i | input | 1 | Serial data bit in absorb mode |
| check_i | input | 1 | Strobe: judge the current remainder |
| tx_bit_o | output | 1 | Serial CRC bit (register top bit) |
| remainder_o | output | 16 | Current register contents |
| err_o | output | 1 | Registered result of the last check |

## Verification
On every cycle, the bound checker checks the per-bit update rules: preset priority, the hold when idle, the absorb feedback step, the emit shift and the registered verdict of a check strobe. Only the bench's scenarios can show the properties that depend on a whole field. These are the known ID-field vector and its zero residue after the appended CRC, the bit-exact CRC on the emit output, and error detection for every single-bit corruption of a field. The bench also sweeps all 256 single-byte inputs against an arithmetic model.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic {
        FEED_ABSORB = 1'b0,
        FEED_EMIT   = 1'b1
    } feed_mode_e;

    typedef struct packed {
        logic step;
        logic din;
    } feed_t;

    typedef struct packed {
        logic clear;
        logic sample;
    } verdict_ctl_t;

endpackage

// File: rtl/crc16_feed_sel.sv
module crc16_feed_sel
    import crc16_pkg::*;
(
    input  feed_mode_e mode,
    input  logic       bit_en,
    input  logic       data_bit,
    input  logic       reg_msb,
    output feed_t      feed,
    output logic       tx_bit
);
    // Emitting equals absorbing the register's own top bit: feedback cancels.
    always_comb begin
        feed.step = bit_en;
        feed.din  = (mode == FEED_EMIT) ? reg_msb : data_bit;
        tx_bit    = reg_msb;
    end
endmodule

// File: rtl/crc16_lfsr.sv
module crc16_lfsr
    import crc16_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY,
    parameter logic [W-1:0] INIT = CRC_INIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset,
    input  feed_t        feed,
    output logic [W-1:0] state
);
    logic         fb;
    logic [W-1:0] nxt;

    assign fb = feed.din ^ state[W-1];

    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign nxt[i] = POLY[i] & fb;
            end else begin : g_upper
                assign nxt[i] = state[i-1] ^ (POLY[i] & fb);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            state <= INIT;
        end else if (feed.step) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/crc16_verdict.sv
module crc16_verdict
    import crc16_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  verdict_ctl_t ctl,
    input  logic [W-1:0] state,
    output logic         err
);
    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            err <= 1'b0;
        end else if (ctl.sample) begin
            err <= |state;
        end
    end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY,
    parameter logic [W-1:0] INIT = CRC_INIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset_i,
    input  logic         bit_en_i,
    input  logic         mode_i,
    input  logic         bit_i,
    input  logic         check_i,
    output logic         tx_bit_o,
    output logic [W-1:0] remainder_o,
    output logic         err_o
);
    feed_t        feed;
    verdict_ctl_t vctl;
    feed_mode_e   mode;

    assign mode        = feed_mode_e'(mode_i);
    assign vctl.clear  = preset_i;
    assign vctl.sample = check_i;

    crc16_feed_sel u_sel (
        .mode     (mode),
        .bit_en   (bit_en_i),
        .data_bit (bit_i),
        .reg_msb  (remainder_o[W-1]),
        .feed     (feed),
        .tx_bit   (tx_bit_o)
    );

    crc16_lfsr #(.W(W), .POLY(POLY), .INIT(INIT)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .preset (preset_i),
        .feed   (feed),
        .state  (remainder_o)
    );

    crc16_verdict #(.W(W)) u_verdict (
        .clk   (clk),
        .rst   (rst),
        .ctl   (vctl),
        .state (remainder_o),
        .err   (err_o)
    );
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input logic         clk,
    input logic         rst,
    input logic         preset_i,
    input logic         bit_en_i,
    input logic         mode_i,
    input logic         bit_i,
    input logic         check_i,
    input logic         tx_bit_o,
    input logic [W-1:0] remainder_o,
    input logic         err_o
);
    // R2 / R3: preset wins over everything else
    a_r3_preset_wins: assert property (@(posedge clk) disable iff (rst)
        preset_i |=> (remainder_o == INIT) && !err_o);

    // R5: idle cycles hold the remainder
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!preset_i && !bit_en_i) |=> $stable(remainder_o));

    // R4: absorb step
    a_r4_absorb: assert property (@(posedge clk) disable iff (rst)
        (!preset_i && bit_en_i && !mode_i) |=>
        remainder_o == ({$past(remainder_o[W-2:0]), 1'b0}
                        ^ ($past(bit_i ^ remainder_o[W-1]) ? POLY : '0)));

    // R6: emit shifts in zeros and drives the top bit
    a_r6_emit: assert property (@(posedge clk) disable iff (rst)
        (!preset_i && bit_en_i && mode_i) |=>
        remainder_o == {$past(remainder_o[W-2:0]), 1'b0});

    a_r6_txbit: assert property (@(posedge clk) disable iff (rst)
        tx_bit_o == remainder_o[W-1]);

    // R7: verdict on strobe, hold otherwise
    a_r7_verdict: assert property (@(posedge clk) disable iff (rst)
        (!preset_i && check_i) |=> err_o == ($past(remainder_o) != '0));

    a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
        (!preset_i && !check_i) |=> $stable(err_o));
endmodule

bind crc16_engine crc16_engine_chk #(.W(W), .POLY(POLY), .INIT(INIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .preset_i    (preset_i),
    .bit_en_i    (bit_en_i),
    .mode_i      (mode_i),
    .bit_i       (bit_i),
    .check_i     (check_i),
    .tx_bit_o    (tx_bit_o),
    .remainder_o (remainder_o),
    .err_o       (err_o)
);

// File: tb/crc16_engine_tb.sv
`timescale 1ns/1ps
module crc16_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        preset_i = 1'b0;
    logic        bit_en_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        check_i = 1'b0;
    logic        tx_bit_o;
    logic [15:0] remainder_o;
    logic        err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    crc16_engine u_dut (
        .clk(clk), .rst(rst), .preset_i(preset_i), .bit_en_i(bit_en_i),
        .mode_i(mode_i), .bit_i(bit_i), .check_i(check_i),
        .tx_bit_o(tx_bit_o), .remainder_o(remainder_o), .err_o(err_o)
    );

    function automatic logic [15:0] mdl_bit(logic [15:0] r, logic d);
        logic fb;
        fb = d ^ r[15];
        return {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [15:0] mdl_byte(logic [15:0] r, logic [7:0] b);
        logic [15:0] t;
        t = r;
        for (int i = 7; i >= 0; i--) t = mdl_bit(t, b[i]);
        return t;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        preset_i = 0; bit_en_i = 0; check_i = 0; mode_i = 0; bit_i = 0;
        tick();
    endtask

    task automatic do_preset();
        preset_i = 1; tick(); preset_i = 0;
    endtask

    task automatic feed_bit(logic b);
        bit_en_i = 1; mode_i = 0; bit_i = b; tick(); bit_en_i = 0;
    endtask

    task automatic feed_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) feed_bit(b[i]);
    endtask

    task automatic do_check();
        check_i = 1; tick(); check_i = 0;
    endtask

    logic [7:0]  idv [8] = '{8'hA1, 8'hA1, 8'hA1, 8'hFE, 8'h00, 8'h00, 8'h01, 8'h02};
    logic [15:0] id_crc;
    logic [79:0] frame;
    logic [15:0] exp_r;

    initial begin
        // R1: reset state
        rst = 1; tick(); tick();
        chk("R1 reset remainder", remainder_o, 16'hFFFF);
        chk("R1 reset err", {15'd0, err_o}, 16'd0);
        rst = 0;

        // R5: idle holds
        idle(); idle(); idle();
        chk("R5 idle after reset", remainder_o, 16'hFFFF);

        // R4: sweep all single bytes from preset
        for (int v = 0; v < 256; v++) begin
            do_preset();
            feed_byte(v[7:0]);
            chk("R4 byte sweep", remainder_o, mdl_byte(16'hFFFF, v[7:0]));
        end

        // R5: hold after data
        exp_r = remainder_o;
        idle(); idle();
        chk("R5 hold with data", remainder_o, exp_r);

        // R8: ID vector generate
        do_preset();
        id_crc = 16'hFFFF;
        for (int k = 0; k < 8; k++) begin
            feed_byte(idv[k]);
            id_crc = mdl_byte(id_crc, idv[k]);
        end
        chk("R8 ID vector CRC", remainder_o, id_crc);

        // R6: emit the CRC, MSB first
        for (int i = 15; i >= 0; i--) begin
            mode_i = 1; bit_en_i = 1;
            #0;
            chk("R6 tx bit", {15'd0, tx_bit_o}, {15'd0, id_crc[i]});
            tick();
        end
        bit_en_i = 0; mode_i = 0;
        chk("R6 emptied after emit", remainder_o, 16'h0000);

        // R8: read side, absorb field plus CRC
        do_preset();
        for (int k = 0; k < 8; k++) feed_byte(idv[k]);
        feed_byte(id_crc[15:8]);
        feed_byte(id_crc[7:0]);
        chk("R8 residue zero", remainder_o, 16'h0000);
        do_check();
        chk("R8 check ok", {15'd0, err_o}, 16'd0);

        // R9 / R7: every single-bit corruption is caught
        for (int p = 0; p < 80; p++) begin
            frame = {idv[0], idv[1], idv[2], idv[3], idv[4], idv[5], idv[6], idv[7], id_crc};
            frame[p] = ~frame[p];
            do_preset();
            for (int i = 79; i >= 0; i--) feed_bit(frame[i]);
            do_check();
            chk("R9 flip detected", {15'd0, err_o}, 16'd1);
        end

        // R7: flag holds without strobe, even as data moves
        feed_byte(8'h00);
        idle();
        chk("R7 err holds", {15'd0, err_o}, 16'd1);

        // R2: preset clears err and reloads
        do_preset();
        chk("R2 preset remainder", remainder_o, 16'hFFFF);
        chk("R2 preset clears err", {15'd0, err_o}, 16'd0);

        // R7: check on nonzero remainder, then check on zero
        feed_byte(8'h5A);
        do_check();
        chk("R7 nonzero sets err", {15'd0, err_o}, 16'd1);

        // R3: preset with bit-enable, emit mode and check in the same cycle
        feed_byte(8'hC3);
        preset_i = 1; bit_en_i = 1; mode_i = 1; bit_i = 1; check_i = 1;
        tick();
        preset_i = 0; bit_en_i = 0; mode_i = 0; bit_i = 0; check_i = 0;
        chk("R3 preset priority remainder", remainder_o, 16'hFFFF);
        chk("R3 preset priority err", {15'd0, err_o}, 16'd0);

        // R7: zero remainder clears err
        for (int i = 0; i < 16; i++) begin
            mode_i = 1; bit_en_i = 1; tick();
        end
        bit_en_i = 0; mode_i = 0;
        do_check();
        chk("R7 zero clears err", {15'd0, err_o}, 16'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule